// File: doc/BRIEF.md
# Inter-Character Timeout Timer Bank

This block holds a small bank of retriggerable down counters, one per serial peripheral, that detect silence on a character stream. Each peripheral drives a count-signal line that toggles, for example once per received character. The block synchronises that line to its clock and reacts to its rising edge. Each rising edge reloads the timer with its programmed timeout, so the timer only runs out once the line has been quiet for that many timer-clock pulses.

The timer clock is a one-cycle enable pulse (`tick`) in the system clock domain. When a timer counts down to zero it raises its bit in a shared sticky status vector. Software clears a bit by writing a one to it. The interrupt line is the OR of the status bits that are enabled. Configuration goes through a simple write port. The status vector is visible at all times on an output.

Top module: `ict_timer_bank`

## Requirements
- R1: After reset the status vector is all zero and `irq` is low.
- R2: A rising edge on `evt_in[i]` reloads timer i from its timeout register. It reaches its effect three clock edges after the input changes: two synchroniser stages, then the load. Timer i sets status bit i on exactly the TOUT-th `tick` pulse after the load, and never without a `tick`.
- R3: A new rising edge while timer i is counting restarts the count from TOUT, so status bit i is set only after TOUT ticks with no further edge.
- R4: A status bit, once set, stays set until it is cleared by a write.
- R5: Writing address 1 clears every status bit whose data bit is 1 and leaves the bits written 0 unchanged. If an expiry and a clear of the same bit meet in one cycle, the bit ends up set.
- R6: `irq` is high exactly when some status bit i is set and its enable bit i is set. The enable mask is written at address 0, in data bits [NUM_TMR-1:0].
- R7: An expired timer stays idle and sets no further status until a new rising edge reloads it.
- R8: A rising edge that loads a TOUT of zero leaves the timer idle, so it never sets its status bit.
- R9: Falling edges on `evt_in` have no effect on any timer.
- R10: The timers run independently. Timeout i is written at address 2+i, in data bits [9:0]. Activity on one timer changes no other timer's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-clock enable pulse, one cycle wide |
| evt_in | input | NUM_TMR | Count-signal lines from the peripherals (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 enable, 1 status clear, 2+i timeout i |
| wr_data | input | CNT_W | Write data |
| sts_o | output | NUM_TMR | Sticky expiry status |
| irq | output | 1 | Enabled-status interrupt |

## Verification
The hardest case to reach is an expiry and a software clear landing on the same bit in the same cycle. The bench produces it by loading a timer with TOUT of one. It then drives the single `tick` and the clear write on the same falling clock edge, and checks that the bit survives. Retriggering is reached by raising the count line again one tick before expiry. Falling-edge immunity is reached by lowering the line mid-count and checking that expiry still comes on the original schedule.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam int unsigned ADDR_ENABLE    = 0;
  localparam int unsigned ADDR_STATUS    = 1;
  localparam int unsigned ADDR_TOUT_BASE = 2;
endpackage

// File: rtl/ict_sync_rise.sv
module ict_sync_rise #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/ict_down_timer.sv
module ict_down_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] tout,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  // reload has priority over a tick in the same cycle
  assign expire = run && tick && !load && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= tout;
      run <= (tout != '0);
    end else if (run && tick) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) run <= 1'b0;
    end
  end
endmodule

// File: rtl/ict_status_reg.sv
module ict_status_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | set;
  end
endmodule

// File: rtl/ict_timer_bank.sv
module ict_timer_bank #(
  parameter int unsigned NUM_TMR     = 3,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = $clog2(NUM_TMR + ict_pkg::ADDR_TOUT_BASE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [NUM_TMR-1:0] evt_in,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [NUM_TMR-1:0] sts_o,
  output logic               irq
);
  logic [NUM_TMR-1:0] en_q;
  logic [NUM_TMR-1:0] rise;
  logic [NUM_TMR-1:0] expire;
  logic [NUM_TMR-1:0] clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(ict_pkg::ADDR_ENABLE))
      en_q <= wr_data[NUM_TMR-1:0];
  end

  assign clr = (wr_en && wr_addr == ADDR_W'(ict_pkg::ADDR_STATUS)) ?
               wr_data[NUM_TMR-1:0] : '0;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [CNT_W-1:0] tout_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tout_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(ict_pkg::ADDR_TOUT_BASE + i))
        tout_q <= wr_data;
    end

    ict_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(evt_in[i]), .rise(rise[i])
    );

    ict_down_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(rise[i]), .tout(tout_q),
      .tick(tick), .expire(expire[i])
    );
  end

  ict_status_reg #(.N(NUM_TMR)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(expire), .clr(clr), .sts(sts_o)
  );

  assign irq = |(sts_o & en_q);
endmodule

// File: rtl/ict_timer_bank_chk.sv
module ict_timer_bank_chk #(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [CNT_W-1:0]   wr_data,
  input logic [NUM_TMR-1:0] sts_o,
  input logic               irq
);
  logic [NUM_TMR-1:0] clr_mask;
  assign clr_mask = (wr_en && wr_addr == ADDR_W'(ict_pkg::ADDR_STATUS)) ?
                    wr_data[NUM_TMR-1:0] : '0;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (sts_o == '0));

  p_tick_needed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((sts_o & ~$past(sts_o)) == '0));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_o) & ~$past(clr_mask) & ~sts_o) == '0));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0 && !tick) |=> ((sts_o & $past(clr_mask)) == '0));

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_o != '0));
endmodule

bind ict_timer_bank ict_timer_bank_chk #(
  .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sts_o(sts_o), .irq(irq)
);

// File: tb/ict_timer_bank_tb.sv
module ict_timer_bank_tb;
  localparam int N = 3;
  localparam int W = 10;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, irq;
  logic [N-1:0] evt_in = '0, sts_o;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ict_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_in(evt_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sts_o(sts_o), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise(input int i);
    @(negedge clk); evt_in[i] = 1'b0; wait_clk(4);
    evt_in[i] = 1'b1; wait_clk(4);
  endtask

  task automatic t_reset;
    wait_clk(1);
    chk("R1 status", sts_o, '0);
    chk("R1 irq", {2'b0, irq}, '0);
  endtask

  task automatic t_basic;
    wr(2, 4);
    rise(0);
    ticks(3);
    chk("R2 before TOUT", sts_o, 3'b000);
    ticks(1);
    chk("R2 at TOUT", sts_o, 3'b001);
    wait_clk(5);
    chk("R4 sticky", sts_o, 3'b001);
    wr(1, 0);
    chk("R5 zero write", sts_o, 3'b001);
    wr(1, 1);
    chk("R5 clear", sts_o, 3'b000);
    ticks(10);
    chk("R7 no reflag", sts_o, 3'b000);
  endtask

  task automatic t_retrigger;
    wr(2, 5);
    rise(0);
    ticks(4);
    rise(0);
    ticks(4);
    chk("R3 retrigger held", sts_o, 3'b000);
    ticks(1);
    chk("R3 expiry after gap", sts_o, 3'b001);
    wr(1, 1);
  endtask

  task automatic t_fall;
    wr(2, 5);
    rise(0);
    ticks(2);
    @(negedge clk); evt_in[0] = 1'b0; wait_clk(4);
    ticks(3);
    chk("R9 falling ignored", sts_o, 3'b001);
    wr(1, 1);
  endtask

  task automatic t_indep;
    wr(2, 3); wr(3, 6);
    rise(0); rise(1);
    ticks(3);
    chk("R10 timer0 only", sts_o, 3'b001);
    ticks(3);
    chk("R10 timer1 later", sts_o, 3'b011);
    wr(1, 3);
  endtask

  task automatic t_zero;
    wr(4, 0);
    rise(2);
    ticks(20);
    chk("R8 zero TOUT", sts_o, 3'b000);
  endtask

  task automatic t_irq;
    wr(4, 2);
    rise(2);
    ticks(2);
    wr(0, 3'b001);
    chk("R6 masked", {2'b0, irq}, 3'b000);
    wr(0, 3'b100);
    chk("R6 enabled", {2'b0, irq}, 3'b001);
    wr(1, 4);
    chk("R6 cleared", {2'b0, irq}, 3'b000);
  endtask

  task automatic t_collide;
    wr(2, 1);
    rise(0);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 10'd1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R5 set wins", sts_o, 3'b001);
    wr(1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_retrigger();
    t_fall();
    t_indep();
    t_zero();
    t_irq();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule